// File: doc/BRIEF.md
# Type-Tagged Register File

This block is a register file in which every entry holds a small data-type tag next to its data word. A tag of zero means the entry is free. Any nonzero tag means the entry is busy and also records what kind of value it holds. Two combinational read ports return the tag and the data together. An operation-write port stores a result whose tag is copied from the operation's first source. The same write can also release either source by clearing its tag.

A separate load port sets the tag and the data directly, for loads and for initialisation. A busy vector shows issue logic which entries are in use. Each read port raises an error flag when it reads a free entry, and the load port flags any attempt to set a type code that is not defined.

Top module: `tagged_regfile`

## Requirements
- R1: A synchronous active-high reset clears every tag to zero, so `busy_o` is all zeros in the cycle after reset.
- R2: Each read port returns, in the same cycle, the 4-bit tag and the 32-bit data of the entry it addresses.
- R3: A read port's `rd_free_err` output is 1 exactly when its enable is high and the addressed entry's tag is zero.
- R4: When `ld_we` is high and `ld_tag` is a defined code, the entry at `ld_addr` holds `ld_tag` and `ld_data` from the next cycle onward.
- R5: Tag value 15 (4'hF) is undefined. The codes 1 to 14 are the only busy codes. A load with tag 15 raises `ld_tag_err` in the same cycle and leaves the addressed entry unchanged.
- R6: When `op_valid` is high, the entry `op_dst` takes `op_data` and the tag that `op_src1` held before the edge.
- R7: When `op_valid` is high, `op_clr_src1` and `op_clr_src2` each clear the tag of their source register to zero. A source whose clear bit is low keeps its tag.
- R8: Conflicts follow this priority: a defined load beats an operation write to the same entry, and an operation write to `op_dst` beats a clear of that same entry.
- R9: Bit i of `busy_o` is 1 exactly when the tag of entry i is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_a | input | 1 | Read port A in use |
| rd_addr_a | input | 4 | Read port A address |
| rd_tag_a | output | 4 | Read port A tag |
| rd_data_a | output | 32 | Read port A data |
| rd_free_err_a | output | 1 | Port A read a free entry |
| rd_en_b | input | 1 | Read port B in use |
| rd_addr_b | input | 4 | Read port B address |
| rd_tag_b | output | 4 | Read port B tag |
| rd_data_b | output | 32 | Read port B data |
| rd_free_err_b | output | 1 | Port B read a free entry |
| op_valid | input | 1 | Operation result write |
| op_dst | input | 4 | Destination register |
| op_src1 | input | 4 | First source (tag donor) |
| op_src2 | input | 4 | Second source |
| op_clr_src1 | input | 1 | Free first source |
| op_clr_src2 | input | 1 | Free second source |
| op_data | input | 32 | Result data |
| ld_we | input | 1 | Direct tag/data load |
| ld_addr | input | 4 | Load address |
| ld_tag | input | 4 | Load tag |
| ld_data | input | 32 | Load data |
| ld_tag_err | output | 1 | Undefined load tag |
| busy_o | output | 16 | Nonzero-tag vector |

## Verification
On every cycle, the assertions check that reset frees all entries, that a destination inherits its donor's tag, that a released source reads as free, that a rejected load changes nothing, and that free-read flags agree with the busy vector. The bench's scenarios cover the collisions: a destination that is also a cleared source, and a load and an operation aimed at the same entry. Long random runs with undefined tags mixed in compare data, tags and flags against a reference model.

// File: rtl/tagrf_pkg.sv
package tagrf_pkg;
    localparam int TAG_W       = 4;
    localparam int DEF_NREGS   = 16;
    localparam int DEF_DATA_W  = 32;
    localparam logic [TAG_W-1:0] TAG_FREE    = '0;
    localparam logic [TAG_W-1:0] TAG_UNDEF   = 4'hF;

    typedef logic [TAG_W-1:0] tag_t;

    function automatic logic tag_defined(input tag_t t);
        return t != TAG_UNDEF;
    endfunction

    function automatic logic tag_busy(input tag_t t);
        return t != TAG_FREE;
    endfunction
endpackage

// File: rtl/tagrf_entry.sv
module tagrf_entry
    import tagrf_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int AW     = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_ok,
    input  logic [AW-1:0]     ld_addr,
    input  tag_t              ld_tag,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              op_valid,
    input  logic [AW-1:0]     op_dst,
    input  logic [AW-1:0]     op_src1,
    input  logic [AW-1:0]     op_src2,
    input  logic              op_clr_src1,
    input  logic              op_clr_src2,
    input  tag_t              donor_tag,
    input  logic [DATA_W-1:0] op_data,
    output tag_t              tag_q,
    output logic [DATA_W-1:0] data_q
);
    localparam logic [AW-1:0] MY_ADDR = AW'(IDX);

    logic ld_hit, dst_hit, clr_hit;
    tag_t tag_d;
    logic [DATA_W-1:0] data_d;

    assign ld_hit  = ld_ok && (ld_addr == MY_ADDR);
    assign dst_hit = op_valid && (op_dst == MY_ADDR);
    assign clr_hit = op_valid && ((op_clr_src1 && op_src1 == MY_ADDR) ||
                                  (op_clr_src2 && op_src2 == MY_ADDR));

    always_comb begin
        tag_d  = tag_q;
        data_d = data_q;
        if (ld_hit) begin
            tag_d  = ld_tag;
            data_d = ld_data;
        end else if (dst_hit) begin
            tag_d  = donor_tag;
            data_d = op_data;
        end else if (clr_hit) begin
            tag_d  = TAG_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tag_q <= TAG_FREE;
        else     tag_q <= tag_d;
        if (!rst) data_q <= data_d;
    end

    // R7 / R8: a clear with no write to this entry frees it
    a_r7_clear_frees: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !dst_hit && !ld_hit) |=> (tag_q == TAG_FREE));
    // R8: a load wins against everything else
    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        ld_hit |=> (tag_q == $past(ld_tag) && data_q == $past(ld_data)));
endmodule

// File: rtl/tagrf_read_port.sv
module tagrf_read_port
    import tagrf_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int AW     = 4,
    parameter int DATA_W = 32
) (
    input  logic                          en,
    input  logic [AW-1:0]                 addr,
    input  tag_t        [NREGS-1:0]       tags,
    input  logic [NREGS-1:0][DATA_W-1:0]  datas,
    output tag_t                          tag,
    output logic [DATA_W-1:0]             data,
    output logic                          free_err
);
    assign tag      = tags[addr];
    assign data     = datas[addr];
    assign free_err = en && !tag_busy(tag);
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile
    import tagrf_pkg::*;
#(
    parameter int NREGS  = DEF_NREGS,
    parameter int DATA_W = DEF_DATA_W,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_a,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [TAG_W-1:0]  rd_tag_a,
    output logic [DATA_W-1:0] rd_data_a,
    output logic              rd_free_err_a,
    input  logic              rd_en_b,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [TAG_W-1:0]  rd_tag_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              rd_free_err_b,
    input  logic              op_valid,
    input  logic [AW-1:0]     op_dst,
    input  logic [AW-1:0]     op_src1,
    input  logic [AW-1:0]     op_src2,
    input  logic              op_clr_src1,
    input  logic              op_clr_src2,
    input  logic [DATA_W-1:0] op_data,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_tag_err,
    output logic [NREGS-1:0]  busy_o
);
    tag_t        [NREGS-1:0]       tags;
    logic [NREGS-1:0][DATA_W-1:0]  datas;
    logic ld_ok;
    tag_t donor_tag;

    assign ld_ok      = ld_we && tag_defined(ld_tag);
    assign ld_tag_err = ld_we && !tag_defined(ld_tag);
    assign donor_tag  = tags[op_src1];

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        tagrf_entry #(.IDX(i), .AW(AW), .DATA_W(DATA_W)) u_entry (
            .clk(clk), .rst(rst),
            .ld_ok(ld_ok), .ld_addr(ld_addr), .ld_tag(ld_tag), .ld_data(ld_data),
            .op_valid(op_valid), .op_dst(op_dst), .op_src1(op_src1), .op_src2(op_src2),
            .op_clr_src1(op_clr_src1), .op_clr_src2(op_clr_src2),
            .donor_tag(donor_tag), .op_data(op_data),
            .tag_q(tags[i]), .data_q(datas[i])
        );
        assign busy_o[i] = tag_busy(tags[i]);
    end

    tagrf_read_port #(.NREGS(NREGS), .AW(AW), .DATA_W(DATA_W)) u_rd_a (
        .en(rd_en_a), .addr(rd_addr_a), .tags(tags), .datas(datas),
        .tag(rd_tag_a), .data(rd_data_a), .free_err(rd_free_err_a));
    tagrf_read_port #(.NREGS(NREGS), .AW(AW), .DATA_W(DATA_W)) u_rd_b (
        .en(rd_en_b), .addr(rd_addr_b), .tags(tags), .datas(datas),
        .tag(rd_tag_b), .data(rd_data_b), .free_err(rd_free_err_b));

    // R1: reset leaves every entry free
    a_r1_reset_frees: assert property (@(posedge clk) rst |=> (busy_o == '0));
    // R6: destination inherits the donor tag and takes the result
    a_r6_inherit: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !(ld_ok && ld_addr == op_dst)) |=>
        (tags[$past(op_dst)] == $past(donor_tag) && datas[$past(op_dst)] == $past(op_data)));
    // R5: an undefined load alone changes nothing
    a_r5_undef_load: assert property (@(posedge clk) disable iff (rst)
        (ld_we && !tag_defined(ld_tag) && !op_valid) |=> (busy_o == $past(busy_o)));
    // R3 / R9: free-read flag agrees with the busy vector
    a_r3_free_flag_a: assert property (@(posedge clk) disable iff (rst)
        rd_free_err_a |-> !busy_o[rd_addr_a]);
    a_r3_free_flag_b: assert property (@(posedge clk) disable iff (rst)
        rd_free_err_b |-> !busy_o[rd_addr_b]);
endmodule

// File: tb/tagged_regfile_tb.sv
module tagged_regfile_tb_top;
    logic clk = 0;
    always #10 clk = ~clk;

    logic rst;
    logic rd_en_a, rd_en_b, rd_free_err_a, rd_free_err_b;
    logic [3:0] rd_addr_a, rd_addr_b, rd_tag_a, rd_tag_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic op_valid, op_clr_src1, op_clr_src2;
    logic [3:0] op_dst, op_src1, op_src2;
    logic [31:0] op_data;
    logic ld_we, ld_tag_err;
    logic [3:0] ld_addr, ld_tag;
    logic [31:0] ld_data;
    logic [15:0] busy_o;

    tagged_regfile dut_i (.*);

    int checks = 0, errors = 0;
    logic [3:0]  m_tag [16];
    logic [31:0] m_data [16];
    bit          m_dv [16];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_valid = 0; op_clr_src1 = 0; op_clr_src2 = 0; ld_we = 0;
        op_dst = 0; op_src1 = 0; op_src2 = 0; op_data = 0;
        ld_addr = 0; ld_tag = 0; ld_data = 0;
    endtask

    task automatic check_outputs();
        logic [15:0] eb;
        for (int i = 0; i < 16; i++) eb[i] = (m_tag[i] != 0);
        chk(busy_o == eb, "R9 busy vector", busy_o, eb);
        chk(rd_tag_a == m_tag[rd_addr_a], "R2 tag port A", rd_tag_a, m_tag[rd_addr_a]);
        chk(rd_tag_b == m_tag[rd_addr_b], "R2 tag port B", rd_tag_b, m_tag[rd_addr_b]);
        if (m_dv[rd_addr_a])
            chk(rd_data_a == m_data[rd_addr_a], "R2 data port A", rd_data_a, m_data[rd_addr_a]);
        if (m_dv[rd_addr_b])
            chk(rd_data_b == m_data[rd_addr_b], "R2 data port B", rd_data_b, m_data[rd_addr_b]);
        chk(rd_free_err_a == (rd_en_a && m_tag[rd_addr_a] == 0), "R3 free read A",
            rd_free_err_a, rd_en_a && m_tag[rd_addr_a] == 0);
        chk(rd_free_err_b == (rd_en_b && m_tag[rd_addr_b] == 0), "R3 free read B",
            rd_free_err_b, rd_en_b && m_tag[rd_addr_b] == 0);
        chk(ld_tag_err == (ld_we && ld_tag == 4'hF), "R5 undefined tag flag",
            ld_tag_err, ld_we && ld_tag == 4'hF);
    endtask

    // inputs set after a negedge; check, clock, update model
    task automatic step();
        logic [3:0]  nt [16];
        logic [31:0] nd [16];
        #1 check_outputs();
        nt = m_tag; nd = m_data;
        if (op_valid) begin
            if (op_clr_src1) nt[op_src1] = 0;      // R7
            if (op_clr_src2) nt[op_src2] = 0;
            nt[op_dst] = m_tag[op_src1];           // R6, R8 dst beats clear
            nd[op_dst] = op_data;
            m_dv[op_dst] = 1;
        end
        if (ld_we && ld_tag != 4'hF) begin         // R4, R8 load beats op
            nt[ld_addr] = ld_tag;
            nd[ld_addr] = ld_data;
            m_dv[ld_addr] = 1;
        end
        @(posedge clk);
        m_tag = nt; m_data = nd;
        @(negedge clk);
    endtask

    task automatic read_at(input logic [3:0] a, input logic [3:0] exp_tag, input string req);
        rd_addr_a = a; rd_en_a = 1;
        #1 chk(rd_tag_a == exp_tag, req, rd_tag_a, exp_tag);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rd_en_a = 0; rd_en_b = 1; rd_addr_a = 0; rd_addr_b = 5;
        rst = 1;
        for (int i = 0; i < 16; i++) begin m_tag[i] = 0; m_data[i] = 0; m_dv[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1 chk(busy_o == 16'h0, "R1 reset clears tags", busy_o, 16'h0);
        chk(rd_free_err_b == 1, "R3 free read after reset", rd_free_err_b, 1);

        // R4 direct load
        ld_we = 1; ld_addr = 3; ld_tag = 5; ld_data = 32'hCAFE0003;
        step(); idle_inputs();
        read_at(3, 4'd5, "R4 load sets tag");

        // R5 undefined code rejected
        ld_we = 1; ld_addr = 4; ld_tag = 4'hF; ld_data = 32'h1;
        #1 chk(ld_tag_err == 1, "R5 flag raised", ld_tag_err, 1);
        step(); idle_inputs();
        read_at(4, 4'd0, "R5 entry unchanged");

        // R6/R7 inherit and release source
        op_valid = 1; op_dst = 7; op_src1 = 3; op_src2 = 3; op_clr_src1 = 1; op_data = 32'h77;
        step(); idle_inputs();
        read_at(7, 4'd5, "R6 inherited tag");
        read_at(3, 4'd0, "R7 source cleared");

        // R8 destination equals cleared source
        op_valid = 1; op_dst = 7; op_src1 = 7; op_src2 = 7; op_clr_src1 = 1; op_clr_src2 = 1;
        op_data = 32'h78;
        step(); idle_inputs();
        read_at(7, 4'd5, "R8 dst beats clear");

        // R7 clear bit low keeps the tag
        ld_we = 1; ld_addr = 9; ld_tag = 4'd9; step(); idle_inputs();
        op_valid = 1; op_dst = 1; op_src1 = 7; op_src2 = 9; op_clr_src1 = 0; op_clr_src2 = 0;
        step(); idle_inputs();
        read_at(9, 4'd9, "R7 kept source 2");
        read_at(7, 4'd5, "R7 kept source 1");

        // R8 load beats op on same entry
        op_valid = 1; op_dst = 7; op_src1 = 9; op_data = 32'h5;
        ld_we = 1; ld_addr = 7; ld_tag = 4'd2; ld_data = 32'hBEEF;
        step(); idle_inputs();
        read_at(7, 4'd2, "R8 load beats op");

        // random mix
        for (int n = 0; n < 600; n++) begin
            rd_en_a = 1'($urandom); rd_en_b = 1'($urandom);
            rd_addr_a = 4'($urandom); rd_addr_b = 4'($urandom);
            op_valid = ($urandom % 3) != 0;
            op_dst = 4'($urandom); op_src1 = 4'($urandom); op_src2 = 4'($urandom);
            op_clr_src1 = 1'($urandom); op_clr_src2 = 1'($urandom);
            op_data = $urandom;
            ld_we = ($urandom % 3) == 0;
            ld_addr = 4'($urandom); ld_tag = 4'($urandom); ld_data = $urandom;
            step();
        end
        idle_inputs();

        // R1 reset again mid-run
        rst = 1; @(posedge clk); @(negedge clk); rst = 0;
        for (int i = 0; i < 16; i++) m_tag[i] = 0;
        #1 chk(busy_o == 16'h0, "R1 second reset", busy_o, 16'h0);
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule